// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block steps an 8-bit processor core with a 16-bit address space through two control-transfer instructions, one bus cycle at a time. It holds the program counter and the 8-bit stack pointer and drives a single memory port. A start pulse marks the cycle in which an opcode is fetched from the current program counter. The byte read in that cycle selects the operation. Opcode 0x20 is an absolute subroutine call, three bytes long. Opcode 0x60 is a return. Any other byte only advances the program counter.

The call runs in six cycles. In order, it reads the opcode, the low target byte, makes an internal stack-bus read, writes the high and then the low program-counter byte to the stack, and reads the high target byte. The value saved on the stack is the address of the call's last operand byte, not of the following instruction. The return adds one to the value it pops, so execution continues right after the three-byte call. The stack lives in page 0x01. The host uses the busy and done flags to know when the next opcode fetch may be issued.

Top module: `subr_seq`

## Requirements
- R1: In reset, the program counter is loaded with RESET_PC and the stack pointer with RESET_SP. Busy and done are low and the strobe rnw is high (1 = read, 0 = write).
- R2: When start is high while idle, that cycle reads the opcode at PC and PC advances by one. Opcode 0x20 starts a call and 0x60 starts a return. Any other byte leaves the block idle, with no done pulse.
- R3: Call cycle 2 reads the low target byte at PC, then PC advances. Call cycle 6 reads the high target byte at PC. After cycle 6, PC equals the high target byte concatenated above the low one.
- R4: Call cycle 3 is a read at address 0x0100 + S and changes neither PC nor S.
- R5: Call cycle 4 writes PC[15:8] to 0x0100 + S and cycle 5 writes PC[7:0] to 0x0100 + S, with S decremented after each write. The 16-bit value saved is the opcode address plus 2.
- R6: rnw is low only in call cycles 4 and 5, and each write address lies in page 0x01.
- R7: A return performs these six cycles: an opcode read at PC; a read at PC (which has advanced by one); a read at 0x0100 + S; a read of the low byte at 0x0100 + S + 1; a read of the high byte at 0x0100 + S + 2; and a read at the popped address. It ends with PC = popped value + 1 and S increased by 2.
- R8: S wraps modulo 256 on both increment and decrement, and PC wraps modulo 65536.
- R9: Busy is high in cycles 2 through 6 of a call or return. Done is high for exactly one cycle, the cycle after cycle 6, and busy is low in that cycle.
- R10: A start pulse that arrives while busy is high has no effect on the bus sequence or on the final PC and S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Marks an opcode fetch cycle |
| rdata | input | 8 | Read data from memory |
| addr | output | 16 | Memory address |
| wdata | output | 8 | Write data, meaningful when rnw is low |
| rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| busy | output | 1 | Sequence in progress (cycles 2 to 6) |
| done | output | 1 | One-cycle pulse after the final cycle |
| pc_now | output | 16 | Current program counter |
| sp_now | output | 8 | Current stack pointer |

## Verification
The assertions assume the host never resets the block in the middle of a sequence, and that rdata is a clean function of the address within each cycle. They also assume start is a synchronous level sampled at the clock edge. The bench meets these assumptions by driving start only at falling edges and by modelling memory as a combinational read from the current address. Writes are stored into a 256-byte stack image on the rising edge. Call targets are generated so that no program byte falls in page 0x01, so stack reads and program reads never alias. A long chain of nested calls is started from a stack pointer near zero, so the stack pointer wraps both on the way down and on the way back up. One call is placed at 0xFFFE, so its high operand byte is read from 0x0000.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int AW = 16;
    localparam int DW = 8;

    localparam logic [DW-1:0] OPC_CALL   = 8'h20;
    localparam logic [DW-1:0] OPC_RET    = 8'h60;
    localparam logic [DW-1:0] STACK_PAGE = 8'h01;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_C_LO,
        ST_C_INT,
        ST_C_PUSHH,
        ST_C_PUSHL,
        ST_C_HI,
        ST_R_DUMMY,
        ST_R_SPK,
        ST_R_POPL,
        ST_R_POPH,
        ST_R_FIX
    } state_e;

    typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_LOAD} pc_op_e;
    typedef enum logic [1:0] {SP_HOLD, SP_INC, SP_DEC} sp_op_e;

    typedef struct packed {
        logic   use_stack;
        logic   wr;
        logic   wr_hi;
        pc_op_e pc_op;
        sp_op_e sp_op;
        logic   lat_lo;
    } uop_t;

    function automatic logic [AW-1:0] stack_addr(input logic [DW-1:0] sp);
        return {STACK_PAGE, sp};
    endfunction
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] opcode,
    output uop_t          uop,
    output logic          busy,
    output logic          done
);
    state_e state_q, state_d;
    logic   done_q;

    always_comb begin
        state_d = state_q;
        uop     = '{use_stack: 1'b0, wr: 1'b0, wr_hi: 1'b0,
                    pc_op: PC_HOLD, sp_op: SP_HOLD, lat_lo: 1'b0};
        unique case (state_q)
            ST_IDLE: if (start) begin
                uop.pc_op = PC_INC;
                if (opcode == OPC_CALL)     state_d = ST_C_LO;
                else if (opcode == OPC_RET) state_d = ST_R_DUMMY;
            end
            ST_C_LO: begin
                uop.pc_op  = PC_INC;
                uop.lat_lo = 1'b1;
                state_d    = ST_C_INT;
            end
            ST_C_INT: begin
                uop.use_stack = 1'b1;
                state_d       = ST_C_PUSHH;
            end
            ST_C_PUSHH: begin
                uop.use_stack = 1'b1;
                uop.wr        = 1'b1;
                uop.wr_hi     = 1'b1;
                uop.sp_op     = SP_DEC;
                state_d       = ST_C_PUSHL;
            end
            ST_C_PUSHL: begin
                uop.use_stack = 1'b1;
                uop.wr        = 1'b1;
                uop.sp_op     = SP_DEC;
                state_d       = ST_C_HI;
            end
            ST_C_HI: begin
                uop.pc_op = PC_LOAD;
                state_d   = ST_IDLE;
            end
            ST_R_DUMMY: state_d = ST_R_SPK;
            ST_R_SPK: begin
                uop.use_stack = 1'b1;
                uop.sp_op     = SP_INC;
                state_d       = ST_R_POPL;
            end
            ST_R_POPL: begin
                uop.use_stack = 1'b1;
                uop.lat_lo    = 1'b1;
                uop.sp_op     = SP_INC;
                state_d       = ST_R_POPH;
            end
            ST_R_POPH: begin
                uop.use_stack = 1'b1;
                uop.pc_op     = PC_LOAD;
                state_d       = ST_R_FIX;
            end
            ST_R_FIX: begin
                uop.pc_op = PC_INC;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_C_HI) || (state_q == ST_R_FIX);
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && state_q != ST_C_HI && state_q != ST_R_FIX) |=> busy); // R10
endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = '0,
    parameter logic [DW-1:0] RESET_SP = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  pc_op_e        pc_op,
    input  sp_op_e        sp_op,
    input  logic          lat_lo,
    input  logic          wr_en,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] sp
);
    logic [DW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc   <= RESET_PC;
            sp   <= RESET_SP;
            lo_q <= '0;
        end else begin
            unique case (pc_op)
                PC_INC:  pc <= pc + 1'b1;
                PC_LOAD: pc <= {rdata, lo_q};
                default: pc <= pc;
            endcase
            unique case (sp_op)
                SP_INC:  sp <= sp + 1'b1;
                SP_DEC:  sp <= sp - 1'b1;
                default: sp <= sp;
            endcase
            if (lat_lo) lo_q <= rdata;
        end
    end

    AST_PC_STILL_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(pc)); // R5
endmodule

// File: rtl/seq_bus.sv
module seq_bus
    import seq_pkg::*;
(
    input  logic          use_stack,
    input  logic          wr,
    input  logic          wr_hi,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] sp,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rnw
);
    always_comb begin
        addr  = use_stack ? stack_addr(sp) : pc;
        rnw   = !wr;
        wdata = '0;
        if (wr) wdata = wr_hi ? pc[AW-1:DW] : pc[DW-1:0];
    end
endmodule

// File: rtl/subr_seq.sv
module subr_seq
    import seq_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 16'h0000,
    parameter logic [DW-1:0] RESET_SP = 8'hFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rnw,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc_now,
    output logic [DW-1:0] sp_now
);
    uop_t uop;

    seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .opcode(rdata),
        .uop(uop), .busy(busy), .done(done)
    );

    seq_regs #(.RESET_PC(RESET_PC), .RESET_SP(RESET_SP)) u_regs (
        .clk(clk), .rst(rst), .pc_op(uop.pc_op), .sp_op(uop.sp_op),
        .lat_lo(uop.lat_lo), .wr_en(uop.wr), .rdata(rdata),
        .pc(pc_now), .sp(sp_now)
    );

    seq_bus u_bus (
        .use_stack(uop.use_stack), .wr(uop.wr), .wr_hi(uop.wr_hi),
        .pc(pc_now), .sp(sp_now),
        .addr(addr), .wdata(wdata), .rnw(rnw)
    );

    AST_PUSH_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        !rnw |-> addr[AW-1:DW] == STACK_PAGE); // R6
    AST_PUSH_STEPS_SP: assert property (@(posedge clk) disable iff (rst)
        !rnw |=> sp_now == DW'($past(sp_now) - 1'b1)); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
endmodule

// File: tb/tb_subr_seq.sv
`timescale 1ns/1ps
module tb_subr_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        rnw, busy, done;
    logic [15:0] pc_now;
    logic [7:0]  sp_now;

    localparam logic [15:0] PC0 = 16'h0400;
    localparam logic [7:0]  SP0 = 8'h05;
    localparam int          DEPTH = 120;

    subr_seq #(.RESET_PC(PC0), .RESET_SP(SP0)) dut (
        .clk(clk), .rst(rst), .start(start), .rdata(rdata),
        .addr(addr), .wdata(wdata), .rnw(rnw), .busy(busy), .done(done),
        .pc_now(pc_now), .sp_now(sp_now)
    );

    always #10 clk = ~clk;

    logic [7:0]  stack_mem [256];
    logic [15:0] op_addr;
    logic [7:0]  op_byte, op_lo, op_hi;
    logic [15:0] ret_list [DEPTH];
    logic [15:0] exp_pc;
    logic [7:0]  exp_sp;
    int checks = 0;
    int errors = 0;

    always_comb begin
        if (addr[15:8] == 8'h01)                rdata = stack_mem[addr[7:0]];
        else if (addr == op_addr)               rdata = op_byte;
        else if (addr == 16'(op_addr + 16'd1))  rdata = op_lo;
        else if (addr == 16'(op_addr + 16'd2))  rdata = op_hi;
        else                                    rdata = addr[7:0] ^ addr[15:8];
    end

    always @(posedge clk) if (!rst && !rnw) stack_mem[addr[7:0]] <= wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus(input string req, input logic [15:0] ea, input logic erw,
                       input logic [7:0] ewd);
        chk(req, 32'(addr), 32'(ea));
        chk({req, "/R6"}, 32'(rnw), 32'(erw));
        if (!erw) chk({req, "/R6"}, 32'(wdata), 32'(ewd));
    endtask

    task automatic do_other(input logic [7:0] opc);
        op_addr = exp_pc; op_byte = opc; op_lo = 8'h00; op_hi = 8'h00;
        @(negedge clk); start = 1'b1; #1;
        bus("R2", exp_pc, 1'b1, 8'h00);
        @(negedge clk); start = 1'b0; #1;
        chk("R2 busy", 32'(busy), 0);
        chk("R2 pc", 32'(pc_now), 32'(16'(exp_pc + 16'd1)));
        @(negedge clk); #1;
        chk("R2 no done", 32'(done), 0);
        exp_pc = 16'(exp_pc + 16'd1);
    endtask

    task automatic do_call(input logic [15:0] tgt, input int depth, input bit poke);
        logic [15:0] ret;
        ret = 16'(exp_pc + 16'd2);
        op_addr = exp_pc; op_byte = 8'h20; op_lo = tgt[7:0]; op_hi = tgt[15:8];
        @(negedge clk); start = 1'b1; #1;
        bus("R2", exp_pc, 1'b1, 8'h00);
        chk("R9 idle", 32'(busy), 0);
        chk("R9 done low", 32'(done), 0);
        @(negedge clk); start = poke; #1;
        bus(poke ? "R3/R10" : "R3", 16'(exp_pc + 16'd1), 1'b1, 8'h00);
        chk("R9 busy", 32'(busy), 1);
        @(negedge clk); #1;
        bus(poke ? "R4/R10" : "R4", {8'h01, exp_sp}, 1'b1, 8'h00);
        start = 1'b0;
        @(negedge clk); #1;
        bus("R5 hi", {8'h01, exp_sp}, 1'b0, ret[15:8]);
        @(negedge clk); #1;
        bus("R5 lo", {8'h01, 8'(exp_sp - 8'd1)}, 1'b0, ret[7:0]);
        @(negedge clk); #1;
        bus("R3 hi", ret, 1'b1, 8'h00);
        chk("R9 no early done", 32'(done), 0);
        @(negedge clk); #1;
        chk("R9 done", 32'(done), 1);
        chk("R9 busy off", 32'(busy), 0);
        chk(poke ? "R3/R10 pc" : "R3 pc", 32'(pc_now), 32'(tgt));
        chk("R8 sp", 32'(sp_now), 32'(8'(exp_sp - 8'd2)));
        ret_list[depth] = ret;
        exp_pc = tgt;
        exp_sp = 8'(exp_sp - 8'd2);
    endtask

    task automatic do_ret(input int depth);
        logic [15:0] pop;
        pop = ret_list[depth];
        op_addr = exp_pc; op_byte = 8'h60; op_lo = 8'h00; op_hi = 8'h00;
        @(negedge clk); start = 1'b1; #1;
        bus("R7", exp_pc, 1'b1, 8'h00);
        @(negedge clk); start = 1'b0; #1;
        bus("R7", 16'(exp_pc + 16'd1), 1'b1, 8'h00);
        @(negedge clk); #1;
        bus("R7", {8'h01, exp_sp}, 1'b1, 8'h00);
        @(negedge clk); #1;
        bus("R7", {8'h01, 8'(exp_sp + 8'd1)}, 1'b1, 8'h00);
        @(negedge clk); #1;
        bus("R7", {8'h01, 8'(exp_sp + 8'd2)}, 1'b1, 8'h00);
        @(negedge clk); #1;
        bus("R7 popped", pop, 1'b1, 8'h00);
        chk("R9 busy", 32'(busy), 1);
        @(negedge clk); #1;
        chk("R9 done", 32'(done), 1);
        chk("R7 pc", 32'(pc_now), 32'(16'(pop + 16'd1)));
        chk("R8 sp", 32'(sp_now), 32'(8'(exp_sp + 8'd2)));
        exp_pc = 16'(pop + 16'd1);
        exp_sp = 8'(exp_sp + 8'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) stack_mem[i] = 8'h00;
        op_addr = 16'h0000; op_byte = 8'h00; op_lo = 8'h00; op_hi = 8'h00;
        rst = 1'b1; start = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pc", 32'(pc_now), 32'(PC0));
        chk("R1 sp", 32'(sp_now), 32'(SP0));
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 rnw", 32'(rnw), 1);
        rst = 1'b0;
        exp_pc = PC0; exp_sp = SP0;

        do_other(8'hEA);
        do_other(8'h00);

        for (int k = 0; k < DEPTH; k++) begin
            logic [15:0] tgt;
            logic [7:0]  hi;
            hi = 8'(k * 29 + 7);
            if (hi < 8'h02) hi = 8'(hi + 8'h02);
            tgt = {hi, 8'(k * 113 + 5)};
            if (k == 50) tgt = 16'hFFFE;
            do_call(tgt, k, (k % 7) == 3);
        end
        chk("R8 pc wrap push", 32'(ret_list[51]), 32'h0000);
        for (int k = DEPTH - 1; k >= 0; k--) do_ret(k);
        chk("R8 sp restored", 32'(sp_now), 32'(SP0));
        do_other(8'h4C);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end
endmodule